// File: doc/BRIEF.md
# Program Counter with Byte-Wide Software Access

This block holds the instruction address counter of a small processor core. The counter is wider than the data bus, so software reaches it through two byte-wide views. The low view is the live low byte of the counter. The high view is a buffer latch that stands between the bus and the counter's upper bits, because those bits cannot be read or written directly.

In normal running the counter steps by one on each instruction-advance strobe. It can also be loaded with a jump or return target in a single cycle.

Software reads the counter low byte first. That read copies the live upper bits into the buffer latch, so a later read of the high view returns bits that belong with the low byte already taken, even if the counter has moved on. Software writes the high view first, which only fills the buffer latch. It then writes the low byte, which loads the whole counter at once from the latch and the bus byte.

Top module: `pc_byte_latch`

## Requirements
- R1: After an asynchronous reset, the counter, the low read view and the high buffer latch are all zero.
- R2: When no software low-byte write and no target load is present, an asserted advance strobe raises the counter by one in the next cycle.
- R3: The counter wraps from 0x3FFF to 0x0000 on an advance.
- R4: A target load places load_addr_i in the counter in the next cycle, and it takes priority over an advance in the same cycle.
- R5: lo_rdata_o always shows bits 7:0 of the counter. A low-byte read strobe copies counter bits 13:8 into the buffer latch, and hi_rdata_o shows that copy from the next cycle on.
- R6: A high write strobe stores wdata_i[5:0] in the buffer latch, and it leaves the counter unchanged apart from a concurrent advance or load.
- R7: A low-byte write strobe loads the counter with {buffer latch, wdata_i} in the next cycle, and it takes priority over both a target load and an advance.
- R8: With no strobe asserted, the counter holds its value. The buffer latch changes only on a low-byte read or a high write.
- R9: When a high write and a low-byte read arrive in the same cycle, the buffer latch takes the written value.
- R10: Once a snapshot has been taken, the buffer latch keeps it while the counter advances, including across a carry into bit 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Instruction-advance strobe |
| load_i | input | 1 | Load a jump or return target |
| load_addr_i | input | 14 | Target address |
| rd_lo_i | input | 1 | Software read of the low byte (snapshots the upper bits) |
| wr_hi_i | input | 1 | Software write to the high buffer latch |
| wr_lo_i | input | 1 | Software write to the low byte (commits the full counter) |
| wdata_i | input | 8 | Software write data |
| pc_o | output | 14 | Live counter value |
| lo_rdata_o | output | 8 | Low-byte read view |
| hi_rdata_o | output | 6 | High buffer latch read view |

## Verification
A wrong buffer latch stays hidden until the next low-byte write or high read. At that point it shows up either as wrong upper bits in pc_o one cycle after the commit, or as a stale value on hi_rdata_o. Because of this, every snapshot and every high write is followed by a readback and by a committed write, across all 64 upper values. Errors in priority or increment show on pc_o in the cycle after the strobe, and a missing carry or wrap shows only at the 0xFF and 0x3FFF boundaries, which the sweeps cross on purpose.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_ADV  = 2'd1,
    SRC_LOAD = 2'd2,
    SRC_SW   = 2'd3
  } pc_src_e;

  // software commit > target load > advance > hold
  function automatic pc_src_e pick_src(input logic sw, input logic ld, input logic adv);
    if (sw)       return SRC_SW;
    else if (ld)  return SRC_LOAD;
    else if (adv) return SRC_ADV;
    else          return SRC_HOLD;
  endfunction
endpackage

// File: rtl/pcl_hi_latch.sv
module pcl_hi_latch #(
  parameter int HI_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            snap_i,
  input  logic [HI_W-1:0] snap_val_i,
  input  logic            wr_i,
  input  logic [HI_W-1:0] wr_val_i,
  output logic [HI_W-1:0] hi_o
);
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_q <= '0;
    else if (wr_i)   hi_q <= wr_val_i;   // write beats snapshot
    else if (snap_i) hi_q <= snap_val_i;
  end

  assign hi_o = hi_q;

  AST_HI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> hi_o == $past(wr_val_i)); // R9
  AST_HI_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_i && !wr_i) |=> hi_o == $past(snap_val_i)); // R5
  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_i && !wr_i) |=> $stable(hi_o)); // R8
endmodule

// File: rtl/pcl_counter.sv
module pcl_counter
  import pcl_pkg::*;
#(
  parameter int PC_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            load_i,
  input  logic [PC_W-1:0] load_addr_i,
  input  logic            commit_i,
  input  logic [PC_W-1:0] commit_val_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q, pc_d;
  pc_src_e         src;

  assign src = pick_src(commit_i, load_i, adv_i);

  always_comb begin
    unique case (src)
      SRC_SW:   pc_d = commit_val_i;
      SRC_LOAD: pc_d = load_addr_i;
      SRC_ADV:  pc_d = pc_q + PC_W'(1);
      default:  pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !commit_i && pc_o != '1) |=> pc_o == $past(pc_o) + PC_W'(1)); // R2
  AST_PC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !commit_i && pc_o == '1) |=> pc_o == '0); // R3
  AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !commit_i) |=> pc_o == $past(load_addr_i)); // R4
  AST_PC_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> pc_o == $past(commit_val_i)); // R7
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i && !commit_i) |=> $stable(pc_o)); // R8
endmodule

// File: rtl/pc_byte_latch.sv
module pc_byte_latch #(
  parameter int PC_W  = 14,
  parameter int BUS_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   adv_i,
  input  logic                   load_i,
  input  logic [PC_W-1:0]        load_addr_i,
  input  logic                   rd_lo_i,
  input  logic                   wr_hi_i,
  input  logic                   wr_lo_i,
  input  logic [BUS_W-1:0]       wdata_i,
  output logic [PC_W-1:0]        pc_o,
  output logic [BUS_W-1:0]       lo_rdata_o,
  output logic [PC_W-BUS_W-1:0]  hi_rdata_o
);
  localparam int HI_W = PC_W - BUS_W;

  logic [PC_W-1:0] pc;
  logic [HI_W-1:0] hi_buf;

  pcl_hi_latch #(.HI_W(HI_W)) u_hi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .snap_i     (rd_lo_i),
    .snap_val_i (pc[PC_W-1:BUS_W]),
    .wr_i       (wr_hi_i),
    .wr_val_i   (wdata_i[HI_W-1:0]),
    .hi_o       (hi_buf)
  );

  pcl_counter #(.PC_W(PC_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (adv_i),
    .load_i       (load_i),
    .load_addr_i  (load_addr_i),
    .commit_i     (wr_lo_i),
    .commit_val_i ({hi_buf, wdata_i}),
    .pc_o         (pc)
  );

  assign pc_o       = pc;
  assign lo_rdata_o = pc[BUS_W-1:0];
  assign hi_rdata_o = hi_buf;

  AST_SNAP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_lo_i && !wr_hi_i && adv_i) |=> $stable(hi_rdata_o)); // R10
endmodule

// File: tb/pc_byte_latch_test.sv
module pc_byte_latch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 0, ld = 0, rd_lo = 0, wr_hi = 0, wr_lo = 0;
  logic [13:0] ld_addr = '0;
  logic [7:0]  wdata = '0;
  logic [13:0] pc;
  logic [7:0]  lo_rd;
  logic [5:0]  hi_rd;

  int checks = 0, failures = 0;
  logic [13:0] exp_pc = '0;
  logic [5:0]  exp_hi = '0;

  always #10 clk = ~clk;

  pc_byte_latch uut (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .load_i(ld), .load_addr_i(ld_addr),
    .rd_lo_i(rd_lo), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wdata_i(wdata),
    .pc_o(pc), .lo_rdata_o(lo_rd), .hi_rdata_o(hi_rd)
  );

  task automatic check(input string req);
    checks++;
    if (pc !== exp_pc || lo_rd !== exp_pc[7:0] || hi_rd !== exp_hi) begin
      failures++;
      $display("FAIL %s pc=%h/%h lo=%h/%h hi=%h/%h", req, pc, exp_pc, lo_rd, exp_pc[7:0], hi_rd, exp_hi);
    end
  endtask

  // drive at negedge, update expectation, one clock, compare at next negedge
  task automatic cyc(input logic a, input logic l, input logic [13:0] la,
                     input logic rl, input logic wh, input logic wl,
                     input logic [7:0] wd, input string req);
    logic [13:0] np;
    logic [5:0]  nh;
    adv = a; ld = l; ld_addr = la; rd_lo = rl; wr_hi = wh; wr_lo = wl; wdata = wd;
    np = wl ? {exp_hi, wd} : l ? la : a ? 14'((int'(exp_pc) + 1) % 16384) : exp_pc;
    nh = wh ? wd[5:0] : rl ? exp_pc[13:8] : exp_hi;
    @(posedge clk); @(negedge clk);
    exp_pc = np; exp_hi = nh;
    check(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // R2 increment, crossing byte carry
    for (int i = 0; i < 300; i++) cyc(1, 0, 0, 0, 0, 0, 0, "R2");
    // R8 hold
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 8'hA5, "R8");
    // R4 load wins over advance, R3 wrap
    cyc(1, 1, 14'h3FFE, 0, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, 0, 0, "R3");
    if (pc !== 14'h0000) begin failures++; $display("FAIL R3 pc=%h exp=0000", pc); end
    checks++;
    // sweep all high values with commits and snapshots
    for (int h = 0; h < 64; h++) begin
      cyc(0, 0, 0, 0, 1, 0, 8'(h | 8'hC0), "R6");
      cyc(1, 1, 14'h1234, 0, 0, 1, 8'(h * 5 + 3), "R7");
      cyc(0, 0, 0, 1, 0, 0, 0, "R5");
      cyc(1, 0, 0, 0, 0, 0, 0, "R10");
    end
    // R10 snapshot survives carry into high bits
    cyc(0, 1, 14'h05FF, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, 0, 0, 0, "R10");
    if (hi_rd !== 6'h05 || pc !== 14'h0600) begin failures++; $display("FAIL R10 hi=%h exp=05 pc=%h exp=0600", hi_rd, pc); end
    checks++;
    // R9 write beats snapshot
    cyc(0, 0, 0, 1, 1, 0, 8'h2A, "R9");
    if (hi_rd !== 6'h2A) begin failures++; $display("FAIL R9 hi=%h exp=2a", hi_rd); end
    checks++;
    // mid-run reset
    cyc(1, 0, 0, 0, 0, 0, 0, "R2");
    rst_n = 1'b0; exp_pc = '0; exp_hi = '0; adv = 0;
    #1 check("R1");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule